// File: doc/BRIEF.md
# Dithered Sine Oscillator

This block is a numerically controlled oscillator that emits a stream of signed sine samples. A 32-bit phase register advances by the value on `phase_inc` on every enabled clock, and wraps modulo 2^32. The output frequency is therefore `phase_inc * f_clk / 2^32`. With an 80 MHz clock, an increment of 536,870,912 gives 10 MHz and 53,687,091 gives about 1 MHz. Before the phase is cut down to the 12 bits that drive the amplitude stage, a 5-bit pseudo-random term is added just below the cut. This dither spreads the truncation spurs into a noise floor.

The amplitude stage stores only one quarter of a sine wave, coarsely, in 33 points. It finds the interval that holds the phase and corrects the coarse value by a multiply of the interval's rise with the fine phase bits. The quadrant bits mirror and negate the result. The output is a 13-bit two's-complement sample.

The sample stream has no ready input. A consumer applies back-pressure by lowering `en`. That freezes the phase register, the dither generator, every pipeline stage, `out_valid` and `out_sample` in the same cycle, so no sample in the sequence is skipped or repeated. `phase_inc` is sampled on each enabled clock.

Top module: `nco_dither_sine`

## Requirements
- R1: On each rising clock edge with `en` high and `rst` low, the phase register takes (phase + `phase_inc`) mod 2^32. Sample n after reset uses the phase sum of the increments applied on the first n enabled edges.
- R2: The dither source is a 16-bit shift register. It shifts left by one on each enabled edge, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. Reset seeds it with 0xACE1. Its bits [4:0] are added to the phase at bit positions [19:15] before the phase is cut to bits [31:20].
- R3: For a truncated phase p (0..4095), the sample lies within 3 counts of round(4095 * sin(2*pi*p/4096)).
- R4: `out_sample` is 13-bit two's complement in the range -4095..4095. It is never positive for p above 2048 and never negative for p below 2048.
- R5: A synchronous `rst` overrides `en`. It clears `out_valid` and `out_sample` to 0, the phase to 0, and loads the dither seed.
- R6: `out_valid` rises on the third enabled edge after reset, counting only edges with `en` high. It then stays high until the next reset.
- R7: While `en` is low, `out_valid`, `out_sample` and all internal state hold. After a pause, the sample sequence continues exactly as if the pause had not happened.
- R8: The first valid sample after reset is exactly 0.
- R9: At the quadrant points p = 0, 1024, 2048 and 3072, the sample is exactly 0, 4095, 0 and -4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low holds everything (back-pressure) |
| phase_inc | input | 32 | Phase step added per enabled clock |
| out_valid | output | 1 | High once the pipeline holds a real sample |
| out_sample | output | 13 | Signed sine sample |

## Verification
The clock enable and the three-stage start-up count can act in the same cycle. A pause can fall inside the fill window, or in the cycle where a sample moves from one stage to the next. The bench drops `en` before and between the first enabled edges after reset, and at random points inside long runs. It also asserts reset while `en` is high. It judges the result in three ways: `out_valid` must rise exactly on the third enabled edge, the outputs must stay frozen through each pause, and every later sample must match a model that only advances on enabled edges.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Truncated phase that feeds the amplitude stage and its split
  localparam int PH_W   = 12;
  localparam int QTR_W  = PH_W - 2;        // bits inside one quadrant
  localparam int SEG_W  = 5;               // coarse interval index bits
  localparam int FINE_W = QTR_W - SEG_W;   // interpolation fraction bits
  localparam int AMP_W  = 12;              // unsigned quarter-wave magnitude
  localparam int OUT_W  = AMP_W + 1;       // signed sample width
  localparam int PROD_W = AMP_W + FINE_W;  // rise * fraction product width
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef struct packed {
    logic             neg;
    logic [AMP_W-1:0] base;
    logic [AMP_W-1:0] next;
    logic [FINE_W-1:0] fine;
  } seg_t;

  // Coarse quarter-wave points: round(4095 * sin(k*pi/64)), k = 0..32
  function automatic logic [AMP_W-1:0] qtr_sine(input logic [SEG_W:0] k);
    case (k)
      6'd0:  qtr_sine = 12'd0;    6'd1:  qtr_sine = 12'd201;
      6'd2:  qtr_sine = 12'd401;  6'd3:  qtr_sine = 12'd601;
      6'd4:  qtr_sine = 12'd799;  6'd5:  qtr_sine = 12'd995;
      6'd6:  qtr_sine = 12'd1189; 6'd7:  qtr_sine = 12'd1380;
      6'd8:  qtr_sine = 12'd1567; 6'd9:  qtr_sine = 12'd1751;
      6'd10: qtr_sine = 12'd1930; 6'd11: qtr_sine = 12'd2105;
      6'd12: qtr_sine = 12'd2275; 6'd13: qtr_sine = 12'd2439;
      6'd14: qtr_sine = 12'd2598; 6'd15: qtr_sine = 12'd2750;
      6'd16: qtr_sine = 12'd2896; 6'd17: qtr_sine = 12'd3034;
      6'd18: qtr_sine = 12'd3165; 6'd19: qtr_sine = 12'd3289;
      6'd20: qtr_sine = 12'd3405; 6'd21: qtr_sine = 12'd3512;
      6'd22: qtr_sine = 12'd3611; 6'd23: qtr_sine = 12'd3702;
      6'd24: qtr_sine = 12'd3783; 6'd25: qtr_sine = 12'd3856;
      6'd26: qtr_sine = 12'd3919; 6'd27: qtr_sine = 12'd3972;
      6'd28: qtr_sine = 12'd4016; 6'd29: qtr_sine = 12'd4051;
      6'd30: qtr_sine = 12'd4075; 6'd31: qtr_sine = 12'd4090;
      default: qtr_sine = 12'd4095;
    endcase
  endfunction
endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr
  import nco_pkg::*;
#(
  parameter int DITHER_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic [DITHER_W-1:0] dither
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  // Maximal-length taps 16,14,13,11
  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk) begin
    if (rst)     state_q <= LFSR_SEED;
    else if (en) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign dither = state_q[DITHER_W-1:0];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int DITHER_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [ACC_W-1:0]    inc,
  input  logic [DITHER_W-1:0] dither,
  output logic [PH_W-1:0]     phase
);
  // dither lands directly below the truncation point
  localparam int DSH = ACC_W - PH_W - DITHER_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] dith_ext;
  logic [ACC_W-1:0] dith_sum;

  assign dith_ext = ACC_W'(dither) << DSH;
  assign dith_sum = acc_q + dith_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      phase <= '0;
    end else if (en) begin
      acc_q <= acc_q + inc;
      phase <= PH_W'(dith_sum >> (ACC_W - PH_W));
    end
  end
endmodule

// File: rtl/nco_sine_gen.sv
module nco_sine_gen
  import nco_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PH_W-1:0]         phase,
  output logic signed [OUT_W-1:0] sample
);
  localparam logic [SEG_W:0] SEG_LAST = (SEG_W+1)'(1 << SEG_W);

  logic [QTR_W:0]    idx;
  logic [SEG_W:0]    seg_lo;
  logic [SEG_W:0]    seg_hi;
  seg_t              seg_d, seg_q;
  logic [AMP_W-1:0]  rise;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prod_rnd;
  logic [OUT_W-1:0]  mag;
  logic [OUT_W-1:0]  signed_mag;

  // Stage A: fold the phase into one quadrant and fetch two coarse points
  always_comb begin
    if (phase[PH_W-2])
      idx = (QTR_W+1)'(1 << QTR_W) - {1'b0, phase[QTR_W-1:0]};
    else
      idx = {1'b0, phase[QTR_W-1:0]};
    seg_lo     = idx[QTR_W:FINE_W];
    seg_hi     = (seg_lo == SEG_LAST) ? seg_lo : seg_lo + 1'b1;
    seg_d.neg  = phase[PH_W-1];
    seg_d.base = qtr_sine(seg_lo);
    seg_d.next = qtr_sine(seg_hi);
    seg_d.fine = idx[FINE_W-1:0];
  end

  // Stage B: correct the coarse value with a multiply, then apply the sign
  always_comb begin
    rise       = seg_q.next - seg_q.base;
    prod       = PROD_W'(rise) * PROD_W'(seg_q.fine);
    prod_rnd   = prod + PROD_W'(1 << (FINE_W - 1));
    mag        = OUT_W'(seg_q.base) + OUT_W'(prod_rnd >> FINE_W);
    signed_mag = seg_q.neg ? OUT_W'(-mag) : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      sample <= '0;
    end else if (en) begin
      seg_q  <= seg_d;
      sample <= signed'(signed_mag);
    end
  end
endmodule

// File: rtl/nco_dither_sine.sv
module nco_dither_sine
  import nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int DITHER_W  = 5,
  parameter bit DITHER_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        phase_inc,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int LAT = 3;  // phase register, segment register, sample register

  logic [DITHER_W-1:0] lfsr_dither;
  logic [DITHER_W-1:0] dither;
  logic [PH_W-1:0]     ph_q;
  logic [LAT-1:0]      fill_q;

  nco_dither_lfsr #(.DITHER_W(DITHER_W)) lfsr_i (
    .clk(clk), .rst(rst), .en(en), .dither(lfsr_dither)
  );

  generate
    if (DITHER_EN) begin : g_dith
      assign dither = lfsr_dither;
    end else begin : g_nodith
      assign dither = '0;
    end
  endgenerate

  nco_phase_acc #(.ACC_W(ACC_W), .DITHER_W(DITHER_W)) acc_i (
    .clk(clk), .rst(rst), .en(en), .inc(phase_inc),
    .dither(dither), .phase(ph_q)
  );

  nco_sine_gen gen_i (
    .clk(clk), .rst(rst), .en(en), .phase(ph_q), .sample(out_sample)
  );

  always_ff @(posedge clk) begin
    if (rst)     fill_q <= '0;
    else if (en) fill_q <= {fill_q[LAT-2:0], 1'b1};
  end

  assign out_valid = fill_q[LAT-1];
endmodule

// File: rtl/nco_dither_sine_chk.sv
module nco_dither_sine_chk
  import nco_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample,
  input logic [PH_W-1:0]         ph_q
);
  // R5
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0));

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(out_sample) && $stable(out_valid) && $stable(ph_q)));

  // R4
  sample_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sample >= -13'sd4095 && out_sample <= 13'sd4095));

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R6
  valid_rise_on_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(en));
endmodule

bind nco_dither_sine nco_dither_sine_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .out_valid(out_valid),
  .out_sample(out_sample), .ph_q(ph_q)
);

// File: tb/nco_dither_sine_tb.sv
`timescale 1ns/1ps
module nco_dither_sine_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        en;
  logic [31:0] inc;
  logic        out_valid;
  logic signed [12:0] out_sample;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic [31:0] m_acc;
  logic [15:0] m_lfsr;
  logic [11:0] m_s1, m_s2, m_out;
  int          m_cnt;

  nco_dither_sine dut_i (
    .clk(clk), .rst(rst), .en(en), .phase_inc(inc),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int sine_ref(input logic [11:0] p);
    real a;
    a = 2.0 * 3.14159265358979 * real'(p) / 4096.0;
    return int'(4095.0 * $sin(a));
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_lfsr = 16'hACE1; m_cnt = 0;
    m_s1 = '0; m_s2 = '0; m_out = '0;
  endtask

  // reset with en high: reset must win (R5)
  task automatic do_reset();
    rst = 1'b1; en = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 valid low in reset", out_valid == 1'b0, int'(out_valid), 0);
    check("R5 sample zero in reset", out_sample == 13'sd0, int'(out_sample), 0);
    rst = 1'b0; en = 1'b0;
    model_reset();
  endtask

  task automatic step(input bit e, input logic [31:0] i, input int tol, input string tag);
    int          prev_s;
    logic        prev_v;
    logic [31:0] d, sm;
    int          exp;
    prev_s = int'(out_sample);
    prev_v = out_valid;
    en = e; inc = i;
    @(negedge clk);
    if (e) begin
      d  = 32'(m_lfsr[4:0]) << 15;
      sm = m_acc + d;
      m_out = m_s2; m_s2 = m_s1; m_s1 = sm[31:20];
      m_acc = m_acc + i;
      m_lfsr = lfsr_next(m_lfsr);
      m_cnt++;
      if (m_cnt < 3) begin
        check("R6 valid low during fill", out_valid == 1'b0, int'(out_valid), 0);
      end else begin
        check("R6 valid high after fill", out_valid == 1'b1, int'(out_valid), 1);
        exp = sine_ref(m_out);
        check(tag, (int'(out_sample) - exp <= tol) && (exp - int'(out_sample) <= tol),
              int'(out_sample), exp);
        if (m_out > 12'd2048)
          check("R4 sign negative half", out_sample <= 13'sd0, int'(out_sample), exp);
        else if (m_out < 12'd2048)
          check("R4 sign positive half", out_sample >= 13'sd0, int'(out_sample), exp);
      end
    end else begin
      check("R7 sample held while idle", int'(out_sample) == prev_s, int'(out_sample), prev_s);
      check("R7 valid held while idle", out_valid == prev_v, int'(out_valid), int'(prev_v));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd24681));
    rst = 1'b1; en = 1'b0; inc = '0;
    repeat (3) @(negedge clk);
    check("R5 reset valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R5 reset sample", out_sample == 13'sd0, int'(out_sample), 0);
    rst = 1'b0;
    model_reset();

    // R6/R7: pauses inside the fill window; R8 first sample exact; R9/R1 quadrant steps and wrap
    step(1'b0, 32'h4000_0000, 0, "R7 idle");
    step(1'b1, 32'h4000_0000, 0, "R8 first");
    step(1'b0, 32'h4000_0000, 0, "R7 idle");
    step(1'b1, 32'h4000_0000, 0, "R8 first");
    step(1'b0, 32'h4000_0000, 0, "R7 idle");
    step(1'b1, 32'h4000_0000, 0, "R8 first sample exactly zero");
    for (int k = 0; k < 9; k++)
      step(1'b1, 32'h4000_0000, 0, "R9 quadrant point exact, R1 wrap");

    // R1: 10 MHz step at 80 MHz (inc = 2^29)
    do_reset();
    for (int k = 0; k < 24; k++)
      step(1'b1, 32'd536870912, 3, "R1 eighth-cycle step");

    // R1: 1 MHz step
    do_reset();
    for (int k = 0; k < 40; k++)
      step(1'b1, 32'd53687091, 3, "R1 slow step");

    // R2: low phase bits sit just under the cut, so the dither decides the carry
    do_reset();
    for (int k = 0; k < 60; k++)
      step(1'b1, 32'h000F_8000, 3, "R2 dither carry into phase");

    // R3/R7: random increments and random enable gaps
    do_reset();
    for (int blk = 0; blk < 8; blk++) begin
      logic [31:0] ri;
      ri = $urandom();
      for (int k = 0; k < 50; k++)
        step(($urandom_range(3, 0) != 0), ri, 3, "R3 amplitude vs sine");
    end

    // R5: reset in the middle of a running stream
    rst = 1'b1; en = 1'b1;
    @(negedge clk);
    check("R5 mid-run reset valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R5 mid-run reset sample", out_sample == 13'sd0, int'(out_sample), 0);
    rst = 1'b0; en = 1'b0;
    model_reset();
    for (int k = 0; k < 6; k++)
      step(1'b1, 32'h1234_5678, 3, "R8 restart after reset");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule